// File: doc/BRIEF.md
# I2C Arbitration Loss and Mode Fallback Unit

This unit sits beside an I2C controller's bit engine. While the controller acts as a bus master, the unit compares every bit the controller releases high with the level actually seen on SDA. When another master pulls SDA low over one of our ones, arbitration is lost. The unit then stops the controller from driving SDA. It also latches a sticky loss status and raises the interrupt flag.

What follows a loss depends on what was being sent. A loss during a data byte or an acknowledge bit sends the controller straight back to idle. A loss while the address byte is going out turns the controller into a slave for the remainder of that byte. The bits already on the bus and those still to come are gathered into an address frame. That frame is compared with the controller's own address and with the general call address. On a match the unit stays in slave mode. After every byte it holds SCL low until software clears the interrupt flag. On a mismatch it falls back to idle.

Bit timing and rate generation stay outside this unit. It consumes synchronous samples of SCL and SDA, a phase code from the bit engine and two software strobes.

Top module: `i2c_arb_fallback`

## Requirements
- R1: In master mode (mode code 1), a rising SCL sample with `tx_bit`=1 and `sda_in`=0 sets `arb_lost` and `irq_flag` when `phase` is 0 (address), 1 (data) or 2 (acknowledge). With `phase`=3 (none), or when the bus reads back what was sent, no loss is flagged.
- R2: `sda_drive_low` is high only in master mode with `phase`≠3 and `tx_bit`=0. It is therefore low from the cycle after a loss onward, whatever `tx_bit` is.
- R3: A loss with `phase` 1 or 2 returns `mode` to 0 (idle).
- R4: A loss with `phase` 0 sets `mode` to 2 (slave). The bus levels of every address bit are collected MSB first into an 8-bit frame: seven address bits, then R/W as bit 0.
- R5: When the collected frame's bits [7:1] equal `own_addr`, whatever the R/W bit, `addr_match` and `irq_flag` are set and `mode` stays 2.
- R6: A frame of 0x00 that does not match the own address sets `gc_match` rather than `addr_match`. A zero address with R/W=1 is not a general call. The two match flags are never set together.
- R7: A frame that matches neither address returns `mode` to 0 at the frame's last bit, with both match flags low.
- R8: In slave mode each later byte spans an acknowledge clock followed by 8 data clocks, and `irq_flag` sets on the 8th data clock. While `irq_flag` is set in slave mode, `scl_hold` asserts from the first low SCL sample. It is released in the cycle after `flag_clr`.
- R9: `arb_lost` remains set until `lost_clr`, and `flag_clr` does not affect it. `flag_clr` clears `irq_flag`.
- R10: In slave mode a stop condition (SDA rising while SCL stays high) returns `mode` to 0 and clears both match flags.
- R11: After reset, `mode` is 0 and all flags are low. `mst_go` moves idle to master. In master mode without a loss, `mode` stays 1 until `mst_done` returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_go | input | 1 | Start master operation (accepted only when idle) |
| mst_done | input | 1 | Master transfer finished, return to idle |
| tx_bit | input | 1 | Bit the controller is currently sending |
| sda_in | input | 1 | Synchronised SDA sample |
| scl_in | input | 1 | Synchronised SCL sample |
| phase | input | 2 | 0 address, 1 data, 2 acknowledge, 3 none |
| own_addr | input | ADDR_W | Own slave address |
| flag_clr | input | 1 | Clear the interrupt flag |
| lost_clr | input | 1 | Clear the arbitration-lost status |
| arb_lost | output | 1 | Sticky arbitration-lost status |
| mode | output | 2 | 0 idle, 1 master, 2 slave |
| addr_match | output | 1 | Own address recognised |
| gc_match | output | 1 | General call recognised |
| irq_flag | output | 1 | Interrupt flag |
| scl_hold | output | 1 | Drive SCL low (clock stretch) |
| sda_drive_low | output | 1 | Drive SDA low |

## Verification
The bench builds the unit with its default parameters: a 7-bit address and general call recognition enabled. This makes the address frame a single byte. Every one of the 256 bus bytes can then be played against two master bytes and three own addresses (0x7F, 0x2A, 0x00). The sweep reaches a loss at each bit position, including the R/W bit, where loss and address decision fall on the same clock. It also covers contention where our zero beats the other master's one, and the own-address-zero case where general call and own match collide. Directed sequences cover data and acknowledge losses, the no-compare phase, and a full slave data byte with clock stretching.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'd0,
      MODE_MASTER = 2'd1,
      MODE_SLAVE  = 2'd2
   } mode_e;

   typedef enum logic [1:0] {
      PH_ADDR = 2'd0,
      PH_DATA = 2'd1,
      PH_ACK  = 2'd2,
      PH_NONE = 2'd3
   } phase_e;

endpackage

// File: rtl/i2c_bus_events.sv
// Edge and stop detection on the sampled bus lines.
module i2c_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic stop_seen
);
   logic scl_q;
   logic sda_q;

   // Lines idle high, so reset to 1 to avoid a phantom edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
      end
   end

   assign scl_rise  = scl_in & ~scl_q;
   assign stop_seen = scl_in & scl_q & sda_in & ~sda_q;
endmodule

// File: rtl/i2c_frame_shift.sv
// Bit counter, shift register and address comparators shared by master and slave.
module i2c_frame_shift #(
   parameter int ADDR_W = 7,
   parameter bit GC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              to_ack,
   input  logic              step,
   input  logic              addr_frame,
   input  logic              sda_in,
   input  logic [ADDR_W-1:0] own_addr,
   output logic              last_bit,
   output logic              own_hit,
   output logic              gc_hit
);
   localparam int SH_W = (ADDR_W + 1 > 8) ? ADDR_W + 1 : 8;
   localparam int CW   = $clog2(SH_W + 1);
   localparam logic [CW-1:0] ACK_MARK  = CW'(SH_W);
   localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W);
   localparam logic [CW-1:0] DATA_LAST = CW'(7);

   logic [SH_W-1:0] sr_q;
   logic [SH_W-1:0] frame_nxt;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   last_idx;
   logic            in_ack;

   assign last_idx  = addr_frame ? ADDR_LAST : DATA_LAST;
   assign in_ack    = cnt_q > last_idx;
   assign frame_nxt = {sr_q[SH_W-2:0], sda_in};
   assign last_bit  = step && !in_ack && (cnt_q == last_idx);
   assign own_hit   = frame_nxt[ADDR_W:1] == own_addr;

   generate
      if (GC_EN) begin : g_gc
         assign gc_hit = frame_nxt[ADDR_W:0] == '0;
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (to_ack) begin
         cnt_q <= ACK_MARK;
      end else if (step) begin
         if (in_ack) begin
            cnt_q <= '0;
         end else begin
            sr_q  <= frame_nxt;
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/i2c_arb_fallback.sv
module i2c_arb_fallback
   import i2c_arb_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter bit GC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mst_go,
   input  logic              mst_done,
   input  logic              tx_bit,
   input  logic              sda_in,
   input  logic              scl_in,
   input  logic [1:0]        phase,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              flag_clr,
   input  logic              lost_clr,
   output logic              arb_lost,
   output logic [1:0]        mode,
   output logic              addr_match,
   output logic              gc_match,
   output logic              irq_flag,
   output logic              scl_hold,
   output logic              sda_drive_low
);
   generate
      if (ADDR_W < 2 || ADDR_W > 15) begin : g_bad_addr_w
         $error("i2c_arb_fallback: ADDR_W must lie in 2..15");
      end
   endgenerate

   phase_e ph;
   mode_e  mode_q, mode_d;
   logic   slv_addr_q, slv_addr_d;
   logic   am_q, am_d, gc_q, gc_d;
   logic   irq_q, irq_d, lost_q, lost_d, hold_q, hold_d;
   logic   scl_rise, stop_seen;
   logic   step, lost_hit, last_bit, own_hit, gc_hit;
   logic   clr, to_ack, eval, addr_frame;

   assign ph = phase_e'(phase);

   i2c_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_rise  (scl_rise),
      .stop_seen (stop_seen)
   );

   // Address bits are counted while mastering too, so a loss can carry on.
   assign step = scl_rise &&
                 (((mode_q == MODE_MASTER) && (ph == PH_ADDR)) || (mode_q == MODE_SLAVE));
   assign addr_frame = (mode_q == MODE_MASTER) || slv_addr_q;
   assign lost_hit = (mode_q == MODE_MASTER) && scl_rise && (ph != PH_NONE) &&
                     tx_bit && !sda_in;

   i2c_frame_shift #(
      .ADDR_W (ADDR_W),
      .GC_EN  (GC_EN)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .to_ack     (to_ack),
      .step       (step),
      .addr_frame (addr_frame),
      .sda_in     (sda_in),
      .own_addr   (own_addr),
      .last_bit   (last_bit),
      .own_hit    (own_hit),
      .gc_hit     (gc_hit)
   );

   always_comb begin
      mode_d     = mode_q;
      slv_addr_d = slv_addr_q;
      am_d       = am_q;
      gc_d       = gc_q;
      irq_d      = irq_q & ~flag_clr;
      lost_d     = lost_q & ~lost_clr;
      clr        = 1'b0;
      to_ack     = 1'b0;
      eval       = 1'b0;
      case (mode_q)
         MODE_IDLE: begin
            if (mst_go) begin
               mode_d = MODE_MASTER;
               clr    = 1'b1;
               am_d   = 1'b0;
               gc_d   = 1'b0;
            end
         end
         MODE_MASTER: begin
            if (lost_hit) begin
               lost_d = 1'b1;
               irq_d  = 1'b1;
               if (ph == PH_ADDR) begin
                  if (last_bit) begin
                     eval = 1'b1;
                  end else begin
                     mode_d     = MODE_SLAVE;
                     slv_addr_d = 1'b1;
                  end
               end else begin
                  mode_d = MODE_IDLE;
               end
            end else if (mst_done) begin
               mode_d = MODE_IDLE;
            end
         end
         MODE_SLAVE: begin
            if (stop_seen) begin
               mode_d     = MODE_IDLE;
               slv_addr_d = 1'b0;
               am_d       = 1'b0;
               gc_d       = 1'b0;
            end else if (last_bit) begin
               if (slv_addr_q) begin
                  eval = 1'b1;
               end else begin
                  irq_d = 1'b1;
               end
            end
         end
         default: mode_d = MODE_IDLE;
      endcase

      // Own address wins over general call when both decode.
      if (eval) begin
         slv_addr_d = 1'b0;
         if (own_hit) begin
            am_d   = 1'b1;
            irq_d  = 1'b1;
            mode_d = MODE_SLAVE;
            to_ack = 1'b1;
         end else if (gc_hit) begin
            gc_d   = 1'b1;
            irq_d  = 1'b1;
            mode_d = MODE_SLAVE;
            to_ack = 1'b1;
         end else begin
            mode_d = MODE_IDLE;
         end
      end

      hold_d = (mode_d == MODE_SLAVE) && irq_d && (hold_q || !scl_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_IDLE;
         slv_addr_q <= 1'b0;
         am_q       <= 1'b0;
         gc_q       <= 1'b0;
         irq_q      <= 1'b0;
         lost_q     <= 1'b0;
         hold_q     <= 1'b0;
      end else begin
         mode_q     <= mode_d;
         slv_addr_q <= slv_addr_d;
         am_q       <= am_d;
         gc_q       <= gc_d;
         irq_q      <= irq_d;
         lost_q     <= lost_d;
         hold_q     <= hold_d;
      end
   end

   assign arb_lost      = lost_q;
   assign mode          = mode_q;
   assign addr_match    = am_q;
   assign gc_match      = gc_q;
   assign irq_flag      = irq_q;
   assign scl_hold      = hold_q;
   assign sda_drive_low = (mode_q == MODE_MASTER) && (ph != PH_NONE) && !tx_bit;
endmodule

// File: rtl/i2c_arb_fallback_chk.sv
module i2c_arb_fallback_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_in,
   input logic       sda_in,
   input logic       lost_clr,
   input logic       arb_lost,
   input logic [1:0] mode,
   input logic       addr_match,
   input logic       gc_match,
   input logic       irq_flag,
   input logic       scl_hold,
   input logic       sda_drive_low
);
   p_lost_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> irq_flag);

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (!sda_drive_low && mode != 2'd1));

   p_match_slave_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match || gc_match) |-> mode == 2'd2);

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_match, gc_match}));

   p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> (irq_flag && mode == 2'd2));

   p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !lost_clr) |=> arb_lost);

   p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && scl_in && $past(scl_in) && sda_in && !$past(sda_in))
      |=> mode == 2'd0);

   p_mode_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);
endmodule

bind i2c_arb_fallback i2c_arb_fallback_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_in        (scl_in),
   .sda_in        (sda_in),
   .lost_clr      (lost_clr),
   .arb_lost      (arb_lost),
   .mode          (mode),
   .addr_match    (addr_match),
   .gc_match      (gc_match),
   .irq_flag      (irq_flag),
   .scl_hold      (scl_hold),
   .sda_drive_low (sda_drive_low)
);

// File: tb/i2c_arb_fallback_tb.sv
module i2c_arb_fallback_tb;
   localparam int CLK_P  = 10;
   localparam int WD_CYC = 190000;

   logic       clk, rst_n, mst_go, mst_done, tx_bit, sda, scl, flag_clr, lost_clr;
   logic [1:0] phase;
   logic [6:0] own_addr;
   logic       arb_lost, addr_match, gc_match, irq_flag, scl_hold, sda_drive_low;
   logic [1:0] mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   i2c_arb_fallback u_dut (
      .clk (clk), .rst_n (rst_n), .mst_go (mst_go), .mst_done (mst_done),
      .tx_bit (tx_bit), .sda_in (sda), .scl_in (scl), .phase (phase),
      .own_addr (own_addr), .flag_clr (flag_clr), .lost_clr (lost_clr),
      .arb_lost (arb_lost), .mode (mode), .addr_match (addr_match),
      .gc_match (gc_match), .irq_flag (irq_flag), .scl_hold (scl_hold),
      .sda_drive_low (sda_drive_low)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic pulse_go();
      mst_go = 1'b1; cyc(); mst_go = 1'b0;
   endtask

   task automatic pulse_done();
      mst_done = 1'b1; cyc(); mst_done = 1'b0;
   endtask

   task automatic pulse_fclr();
      flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
   endtask

   task automatic pulse_lclr();
      lost_clr = 1'b1; cyc(); lost_clr = 1'b0;
   endtask

   // One bit: SCL low, set data, SCL high; rise is registered on the next edge.
   task automatic send_bit(input logic tx, input logic busv);
      scl = 1'b0; tx_bit = tx; sda = busv;
      cyc(); cyc();
      scl = 1'b1;
      cyc(); cyc();
   endtask

   // Stop condition starting from SCL low.
   task automatic send_stop();
      sda = 1'b0; cyc();
      scl = 1'b1; cyc();
      sda = 1'b1; cyc();
   endtask

   task automatic run_trial(input logic [6:0] own, input logic [7:0] m, input logic [7:0] b);
      logic [7:0] r;
      bit         lostf;
      int         lpos;
      bit         exp_am, exp_gc;
      lostf = 1'b0; lpos = -1; r = '0;
      own_addr = own; phase = 2'd0;
      pulse_go();
      chk("R11 mst_go enters master", int'(mode), 1);
      for (int i = 7; i >= 0; i--) begin
         logic busv;
         if (!lostf) begin
            busv = m[i] & b[i];
            if (m[i] && !b[i]) begin
               lostf = 1'b1;
               lpos  = i;
            end
         end else begin
            busv = b[i];
         end
         r[i] = busv;
         send_bit(m[i], busv);
         if (lostf && lpos == i) begin
            chk("R1 loss flagged on address bit", int'(arb_lost), 1);
            chk("R2 master mode left after loss", int'(mode != 2'd1), 1);
            tx_bit = 1'b0; #1;
            chk("R2 SDA released after loss", int'(sda_drive_low), 0);
            if (i > 0) chk("R4 slave mode mid-address", int'(mode), 2);
         end
      end
      if (!lostf) begin
         chk("R11 master kept without loss", int'(mode), 1);
         chk("R1 no loss when bus agrees", int'(arb_lost), 0);
         pulse_done();
         chk("R11 mst_done to idle", int'(mode), 0);
      end else begin
         exp_am = (r[7:1] == own);
         exp_gc = !exp_am && (r == 8'h00);
         chk("R5 own address match", int'(addr_match), int'(exp_am));
         chk("R6 general call match", int'(gc_match), int'(exp_gc));
         chk("R1 irq on loss", int'(irq_flag), 1);
         if (exp_am || exp_gc) begin
            chk("R4 stays slave after match", int'(mode), 2);
            scl = 1'b0; cyc();
            chk("R8 SCL held after address", int'(scl_hold), 1);
            pulse_fclr();
            chk("R8 SCL released by flag clear", int'(scl_hold), 0);
            chk("R9 irq cleared", int'(irq_flag), 0);
            chk("R9 lost survives flag clear", int'(arb_lost), 1);
            send_stop();
            chk("R10 stop returns to idle", int'(mode), 0);
            chk("R10 match flags cleared", int'(addr_match | gc_match), 0);
         end else begin
            chk("R7 mismatch returns to idle", int'(mode), 0);
            pulse_fclr();
         end
         pulse_lclr();
         chk("R9 lost cleared by lost_clr", int'(arb_lost), 0);
      end
      scl = 1'b1; sda = 1'b1; cyc();
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] db;
      rst_n = 1'b0; mst_go = 1'b0; mst_done = 1'b0; tx_bit = 1'b1;
      sda = 1'b1; scl = 1'b1; flag_clr = 1'b0; lost_clr = 1'b0;
      phase = 2'd3; own_addr = 7'h2A;
      repeat (3) cyc();
      rst_n = 1'b1; cyc();
      chk("R11 reset mode", int'(mode), 0);
      chk("R11 reset flags", int'({arb_lost, addr_match, gc_match, irq_flag, scl_hold}), 0);

      // Data, acknowledge and no-compare phases.
      phase = 2'd0; pulse_go();
      tx_bit = 1'b0; #1;
      chk("R2 master drives zero", int'(sda_drive_low), 1);
      db = 8'h54;
      for (int i = 7; i >= 0; i--) send_bit(db[i], db[i]);
      chk("R11 clean address keeps master", int'(mode), 1);
      phase = 2'd1;
      send_bit(1'b0, 1'b0);
      send_bit(1'b1, 1'b1);
      chk("R1 no loss on agreeing data", int'(arb_lost), 0);
      send_bit(1'b1, 1'b0);
      chk("R1 data loss flagged", int'(arb_lost), 1);
      chk("R3 data loss to idle", int'(mode), 0);
      chk("R1 data loss irq", int'(irq_flag), 1);
      pulse_fclr();
      chk("R9 flag clear keeps lost", int'(arb_lost), 1);
      chk("R9 flag clear drops irq", int'(irq_flag), 0);
      pulse_lclr();
      phase = 2'd2; pulse_go();
      send_bit(1'b1, 1'b0);
      chk("R3 ack loss to idle", int'(mode), 0);
      chk("R1 ack loss flagged", int'(arb_lost), 1);
      pulse_fclr(); pulse_lclr();
      phase = 2'd3; pulse_go();
      send_bit(1'b1, 1'b0);
      chk("R1 no compare in phase none", int'(arb_lost), 0);
      chk("R11 master kept in phase none", int'(mode), 1);
      pulse_done();
      chk("R11 done to idle", int'(mode), 0);
      scl = 1'b1; sda = 1'b1; cyc();

      // Slave data byte with stretching.
      own_addr = 7'h2A; phase = 2'd0; pulse_go();
      db = 8'h54;
      for (int i = 7; i >= 0; i--) send_bit(1'b1, db[i]);
      chk("R5 own match after loss", int'(addr_match), 1);
      scl = 1'b0; cyc();
      chk("R8 hold after address", int'(scl_hold), 1);
      pulse_fclr();
      chk("R8 release after clear", int'(scl_hold), 0);
      send_bit(1'b1, 1'b0);
      chk("R8 ack clock sets no irq", int'(irq_flag), 0);
      db = 8'h3C;
      for (int i = 7; i >= 1; i--) send_bit(1'b1, db[i]);
      chk("R8 no irq before 8th data bit", int'(irq_flag), 0);
      send_bit(1'b1, db[0]);
      chk("R8 irq on 8th data bit", int'(irq_flag), 1);
      chk("R8 no hold while SCL high", int'(scl_hold), 0);
      scl = 1'b0; cyc();
      chk("R8 hold after data byte", int'(scl_hold), 1);
      pulse_fclr();
      chk("R8 release after data clear", int'(scl_hold), 0);
      send_stop();
      chk("R10 stop ends slave", int'(mode), 0);
      pulse_lclr();
      scl = 1'b1; sda = 1'b1; cyc();

      // Sweep every bus byte against two master bytes and three own addresses.
      for (int oi = 0; oi < 3; oi++) begin
         logic [6:0] own;
         own = (oi == 0) ? 7'h7F : ((oi == 1) ? 7'h2A : 7'h00);
         for (int mi = 0; mi < 2; mi++) begin
            logic [7:0] mb;
            mb = (mi == 0) ? 8'hFF : 8'hA5;
            for (int bv = 0; bv < 256; bv++) begin
               run_trial(own, mb, 8'(bv));
            end
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule